// File: doc/BRIEF.md
# Seconds Counter with Per-Byte Increment Setting

This block keeps a 32-bit count of elapsed seconds. A one-cycle tick input, produced elsewhere once per second, advances the whole value by one with full carry propagation. A small byte-wide bus lets a processor read the count, clear it, and adjust it.

The count is never loaded directly. Software sets the time by writing an adjust byte in which zero bits select count bytes. Each selected byte takes a single increment. A byte whose top bit is set blocks direct increments of the byte above it, so that byte can then only move through a carry. Software therefore sets the most significant byte first and works downward.

Increments that one write requests, and a tick that lands in the same cycle, all ripple through one shared carry chain. They interact rather than act independently.

Top module: `seconds_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0x00000000.
- R2: `rd_data` shows one count byte, selected by `addr`. Offset 0 gives bits 31:24, offset 1 gives bits 23:16, offset 2 gives bits 15:8 and offset 3 gives bits 7:0. `count` always shows all 32 bits.
- R3: A write to offset 0 clears the count to zero whatever the data. The clear takes priority over a tick in the same cycle.
- R4: A tick with no write in the same cycle adds one to the 32-bit count with full carry. 0xFFFFFFFF wraps to 0x00000000.
- R5: A write to offset 1 is an adjust. Data bit 4 low increments byte 3 (bits 31:24). Bit 3 low increments byte 2, bit 2 low increments byte 1, and bit 1 low increments byte 0 (bits 7:0).
- R6: Adjust data bits 7, 6, 5 and 0 have no effect. An adjust with bits 4..1 all high leaves the count unchanged.
- R7: A direct increment of byte k (k = 1..3) is suppressed when bit 7 of byte k-1 is set before the write. Byte 0 is never suppressed.
- R8: A byte increment wraps from 0xFF to 0x00 and carries one into the byte above, and that byte takes the carry even when its own direct increment is suppressed. A carry out of byte 3 is discarded.
- R9: A tick in the same cycle as an adjust adds one more at bit 0 of the same carry chain.
- R10: Writes to offsets 2 and 3, and cycles with no write and no tick, leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Byte offset for reads and writes |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Count byte selected by `addr` |
| count | output | 32 | Full count value |

## Verification
Single-byte adjusts are applied one lane at a time. A write that selects all four lanes then shows that every lane decodes to the right bit. Adjust bytes with only the ignored bits varied show that those bits are masked. Long runs of single-lane increments walk a byte across 0x7F to 0x80 and across 0xFF to 0x00. These runs separate three cases: suppression by the lower byte's top bit, carry that still gets through, and the discarded carry out of the top byte. Coincident tick-with-clear and tick-with-adjust cycles settle the priority rule and the shared carry chain.

// File: rtl/secctr_pkg.sv
package secctr_pkg;

    localparam int unsigned LANE_W_DEF    = 8;
    localparam int unsigned NUM_LANES_DEF = 4;
    localparam int unsigned ADJ_LSB_DEF   = 1;

    // Bus offsets; behaviour depends on these two values
    typedef enum logic [1:0] {
        OFS_CLEAR  = 2'd0,
        OFS_ADJUST = 2'd1,
        OFS_SPARE2 = 2'd2,
        OFS_SPARE3 = 2'd3
    } ofs_e;

    // Decoded per-cycle command
    typedef struct packed {
        logic clear;   // write to clear offset
        logic adjust;  // write to adjust offset
        logic noop;    // adjust selecting no lane
        logic tick;    // one-second pulse
    } cmd_t;

    // Lane select mask within the adjust byte
    function automatic logic [7:0] lane_mask(input int unsigned lsb, input int unsigned n);
        logic [7:0] m;
        m = '0;
        for (int unsigned i = 0; i < 8; i++) begin
            if (i >= lsb && i < lsb + n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/secctr_cmd_decode.sv
module secctr_cmd_decode
    import secctr_pkg::*;
#(
    parameter int unsigned NUM_LANES = NUM_LANES_DEF,
    parameter int unsigned ADJ_LSB   = ADJ_LSB_DEF
) (
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [7:0]           wr_data,
    input  logic                 tick,
    output cmd_t                 cmd,
    output logic [NUM_LANES-1:0] lane_req
);
    localparam logic [7:0] SEL_MASK = lane_mask(ADJ_LSB, NUM_LANES);

    logic [7:0] eff_bits;   // unselected positions forced high
    logic       is_adjust;

    assign is_adjust = wr_en && (ofs_e'(addr) == OFS_ADJUST);
    assign eff_bits  = wr_data | ~SEL_MASK;

    always_comb begin
        cmd.clear  = wr_en && (ofs_e'(addr) == OFS_CLEAR);
        cmd.adjust = is_adjust;
        cmd.noop   = is_adjust && (&eff_bits);
        cmd.tick   = tick;
    end

    // Active-low lane selects
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_req
        assign lane_req[k] = is_adjust && !eff_bits[ADJ_LSB + k];
    end

endmodule

// File: rtl/secctr_lane.sv
module secctr_lane #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         direct_req,
    input  logic         lower_sign,
    input  logic         carry_in,
    output logic [W-1:0] nxt,
    output logic         carry_out
);
    logic [1:0] inc;
    logic [W:0] sum;

    // A set top bit below blocks the direct request; carry always passes
    assign inc = {1'b0, direct_req && !lower_sign} + {1'b0, carry_in};
    assign sum = {1'b0, cur} + (W+1)'(inc);

    assign nxt       = sum[W-1:0];
    assign carry_out = sum[W];

endmodule

// File: rtl/secctr_read_mux.sv
module secctr_read_mux #(
    parameter int unsigned W         = 8,
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned ADDR_W    = 2
) (
    input  logic [W*NUM_LANES-1:0] value,
    input  logic [ADDR_W-1:0]      addr,
    output logic [W-1:0]           byte_out
);
    // Offset 0 is the most significant lane
    always_comb begin
        byte_out = '0;
        for (int unsigned i = 0; i < NUM_LANES; i++) begin
            if (addr == ADDR_W'(i)) byte_out = value[(NUM_LANES-1-i)*W +: W];
        end
    end

endmodule

// File: rtl/seconds_counter.sv
module seconds_counter
    import secctr_pkg::*;
#(
    parameter int unsigned LANE_W    = LANE_W_DEF,
    parameter int unsigned NUM_LANES = NUM_LANES_DEF,
    parameter int unsigned ADJ_LSB   = ADJ_LSB_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic [31:0] count
);
    localparam int unsigned CNT_W = LANE_W * NUM_LANES;

    cmd_t                 cmd;
    logic [NUM_LANES-1:0] lane_req;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     cnt_nxt;
    logic [NUM_LANES:0]   carry;

    secctr_cmd_decode #(
        .NUM_LANES (NUM_LANES),
        .ADJ_LSB   (ADJ_LSB)
    ) u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .tick     (tick),
        .cmd      (cmd),
        .lane_req (lane_req)
    );

    // The tick enters the chain at the least significant lane
    assign carry[0] = cmd.tick;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic sign_below;
        if (k == 0) begin : g_first
            assign sign_below = 1'b0;
        end else begin : g_upper
            assign sign_below = cnt_q[k*LANE_W - 1];
        end
        secctr_lane #(.W(LANE_W)) u_lane (
            .cur        (cnt_q[k*LANE_W +: LANE_W]),
            .direct_req (lane_req[k]),
            .lower_sign (sign_below),
            .carry_in   (carry[k]),
            .nxt        (cnt_nxt[k*LANE_W +: LANE_W]),
            .carry_out  (carry[k+1])
        );
    end

    // carry[NUM_LANES] leaves the top lane and is dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cmd.clear) begin
            cnt_q <= '0;
        end else if (cmd.adjust || cmd.tick) begin
            cnt_q <= cnt_nxt;
        end
    end

    secctr_read_mux #(
        .W         (LANE_W),
        .NUM_LANES (NUM_LANES),
        .ADDR_W    (2)
    ) u_rmux (
        .value    (cnt_q),
        .addr     (addr),
        .byte_out (rd_data)
    );

    assign count = cnt_q;

    // R1
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));

    // R3: clear beats tick
    p_clear_wins_r3: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (cnt_q == '0));

    // R4
    p_tick_step_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd.tick && !wr_en) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R6
    p_noop_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.noop && !cmd.tick) |=> $stable(cnt_q));

    // R7: top lane alone requested while lane below has its sign set
    p_top_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.adjust && !cmd.tick && lane_req == (NUM_LANES'(1) << (NUM_LANES-1))
         && cnt_q[(NUM_LANES-1)*LANE_W - 1]) |=> $stable(cnt_q));

    // R10
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!cmd.tick && !cmd.clear && !cmd.adjust) |=> $stable(cnt_q));

endmodule

// File: tb/test_seconds_counter.sv
module test_seconds_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [31:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    seconds_counter i_seconds_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .count   (count)
    );

    typedef struct packed {
        logic [1:0]  a;
        logic        w;
        logic [7:0]  d;
        logic        t;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 8'hA5, 1'b0, 32'h00000000},  // R3 clear with data
        '{2'd1, 1'b1, 8'hFD, 1'b0, 32'h00000001},  // R5 byte 0
        '{2'd1, 1'b1, 8'hFB, 1'b0, 32'h00000101},  // R5 byte 1
        '{2'd1, 1'b1, 8'hF7, 1'b0, 32'h00010101},  // R5 byte 2
        '{2'd1, 1'b1, 8'hEF, 1'b0, 32'h01010101},  // R5 byte 3
        '{2'd1, 1'b1, 8'hE1, 1'b0, 32'h02020202},  // R5 all four lanes
        '{2'd1, 1'b1, 8'h1F, 1'b0, 32'h02020202},  // R6 bits 7..5 low
        '{2'd1, 1'b1, 8'h1E, 1'b0, 32'h02020202},  // R6 bit 0 low
        '{2'd0, 1'b0, 8'h00, 1'b1, 32'h02020203},  // R4 tick
        '{2'd2, 1'b1, 8'h00, 1'b0, 32'h02020203},  // R10 offset 2
        '{2'd3, 1'b1, 8'h00, 1'b0, 32'h02020203},  // R10 offset 3
        '{2'd1, 1'b1, 8'hFD, 1'b1, 32'h02020205},  // R9 tick plus adjust
        '{2'd0, 1'b1, 8'h3C, 1'b1, 32'h00000000}   // R3 clear beats tick
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, clear at next negedge (after the posedge)
    task automatic op(input logic [1:0] a, input logic w, input logic [7:0] d, input logic t);
        @(negedge clk);
        addr = a; wr_en = w; wr_data = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; wr_data = 8'h00;
    endtask

    task automatic adj_n(input logic [7:0] d, input int n);
        for (int i = 0; i < n; i++) op(2'd1, 1'b1, d, 1'b0);
    endtask

    task automatic read_byte(input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check8("R2 read", rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check32("R1 reset", count, 32'h0);
        read_byte(2'd0, 8'h00);   // R2 after reset

        // R10 idle
        op(2'd0, 1'b0, 8'h00, 1'b0);
        check32("R10 idle", count, 32'h0);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].a, VECS[i].w, VECS[i].d, VECS[i].t);
            check32($sformatf("vector %0d", i), count, VECS[i].exp);
        end

        // R7: raise byte 0 to 0x80, then byte 1 requests are blocked
        adj_n(8'hFD, 128);
        check32("R5 byte0 run", count, 32'h00000080);
        op(2'd1, 1'b1, 8'hFB, 1'b0);
        check32("R7 byte1 blocked", count, 32'h00000080);
        op(2'd1, 1'b1, 8'hF9, 1'b0);
        check32("R7 byte0 free byte1 blocked", count, 32'h00000081);
        // R8: carry still passes
        adj_n(8'hFD, 127);
        check32("R8 carry into byte1", count, 32'h00000100);
        adj_n(8'hFD, 255);
        check32("R8 byte0 at FF", count, 32'h000001FF);
        op(2'd1, 1'b1, 8'hF9, 1'b0);
        check32("R8 carry with blocked direct", count, 32'h00000200);
        read_byte(2'd2, 8'h02);
        read_byte(2'd3, 8'h00);

        // R8: top byte wrap discards carry
        op(2'd0, 1'b1, 8'hFF, 1'b0);
        adj_n(8'hEF, 255);
        check32("R5 top byte run", count, 32'hFF000000);
        read_byte(2'd0, 8'hFF);
        read_byte(2'd1, 8'h00);
        op(2'd1, 1'b1, 8'hEF, 1'b0);
        check32("R8 top wrap", count, 32'h00000000);

        // Build all-ones from the top down, then tick wraps (R4)
        adj_n(8'hEF, 255);
        adj_n(8'hF7, 255);
        adj_n(8'hFB, 255);
        adj_n(8'hFD, 255);
        check32("R5 build all ones", count, 32'hFFFFFFFF);
        op(2'd1, 1'b1, 8'hEF, 1'b0);
        check32("R7 top byte blocked", count, 32'hFFFFFFFF);
        op(2'd0, 1'b0, 8'h00, 1'b1);
        check32("R4 tick wrap", count, 32'h00000000);

        // R9: tick and byte0 request carry across FF together
        adj_n(8'hFD, 255);
        op(2'd1, 1'b1, 8'hFD, 1'b1);
        check32("R9 double increment wrap", count, 32'h00000101);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check32("R1 reset mid-run", count, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule